// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a 16-bit synchronous binary up-counter built from four identical 4-bit slices. Each slice can be cleared, preset from a parallel data input, or counted up by one. Every action takes place on the rising clock edge. Each slice has two count enables. The first, the broadside enable, goes to every slice at once. The second, the chain enable, passes from slice to slice. A slice counts only when both enables are high.

A slice raises its terminal-count output when its value is all ones and its chain enable is high. That output drives the chain enable of the next slice up, and the lowest slice takes its chain enable from an external pin. The cascade therefore moves every carry on the same edge and needs no ripple through the clock.

The controls have a fixed priority: clear first, then load, then count. When neither clear nor load is active and either enable is low, the count holds.

Top module: `cascade_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `q` becomes 0 after that edge, whatever `ld_n`, `din`, `cnt_en` and `chain_en` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `q` takes the value of `din` after that edge, even when `cnt_en` or `chain_en` is 0.
- R3: When `clr_n`, `ld_n`, `cnt_en` and `chain_en` are all 1 at a rising edge, `q` increases by one after that edge.
- R4: When `chain_en` is 0 and neither clear nor load is active, `q` holds its value, and `carry_out` is 0 while `chain_en` is 0.
- R5: When `cnt_en` is 0 and neither clear nor load is active, `q` holds its value.
- R6: `carry_out` is 1 exactly when `chain_en` is 1 and `q` is 16'hFFFF. It is combinational and is not delayed by a clock.
- R7: Counting from 16'hFFFF wraps `q` to 16'h0000.
- R8: A carry out of any 4-bit slice moves into the next slice on the same edge. For example, 16'h00FF counts to 16'h0100 in one cycle, and 16'h0FFF counts to 16'h1000 in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action happens on the rising edge |
| clr_n | input | 1 | Synchronous clear, active low; highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low |
| din | input | 16 | Parallel preset value |
| cnt_en | input | 1 | Broadside count enable, shared by all slices |
| chain_en | input | 1 | Chain enable into the lowest slice |
| q | output | 16 | Counter value |
| carry_out | output | 1 | Terminal count of the highest slice |

## Verification
Directed cases preset the counter just below the slice boundaries 16'h00FF and 16'h0FFF and at 16'hFFFF, then count once. These cases show whether carries move through the chain on a single edge and whether the counter wraps. Further cases assert clear and load together with enables that are low or that conflict, which tests the control priority. Separate cases drop only `cnt_en` or only `chain_en`, so a hold caused by one enable is told apart from a hold caused by the other, and `carry_out` is checked while `chain_en` is low at all ones. A long run of random clear, load and enable patterns, with loads biased toward values near all ones, is compared every cycle against an integer reference model.

// File: rtl/cnt_slice.sv
module cnt_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         ld_n,
  input  logic         cep,
  input  logic         cet,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  always_ff @(posedge clk) begin
    if (!clr_n)          q <= '0;
    else if (!ld_n)      q <= d;
    else if (cep && cet) q <= q + 1'b1;
  end

  assign tc = cet & (&q);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);
  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> q == $past(d));
  p_count_r3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && cep && cet) |=> q == $past(q) + 1'b1);
  p_hold_r5: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(cep && cet)) |=> $stable(q));
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int SW = 4,
  parameter int NS = 4,
  localparam int TW = SW * NS
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          ld_n,
  input  logic [TW-1:0] din,
  input  logic          cnt_en,
  input  logic          chain_en,
  output logic [TW-1:0] q,
  output logic          carry_out
);
  logic [NS:0] chain;
  assign chain[0] = chain_en;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    cnt_slice #(.W(SW)) u_slice (
      .clk  (clk),
      .clr_n(clr_n),
      .ld_n (ld_n),
      .cep  (cnt_en),
      .cet  (chain[i]),
      .d    (din[i*SW +: SW]),
      .q    (q[i*SW +: SW]),
      .tc   (chain[i+1])
    );
  end

  assign carry_out = chain[NS];

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | !clr_n;

  p_carry_r6: assert property (@(posedge clk) disable iff (!armed)
    carry_out |-> (chain_en && q == '1));
  p_carry_low_r4: assert property (@(posedge clk) disable iff (!armed)
    !chain_en |-> !carry_out);
  p_chain_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !chain_en) |=> $stable(q));
  p_count_r8: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && cnt_en && chain_en) |=> q == $past(q) + 1'b1);
endmodule

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic clr_n = 1'b1, ld_n = 1'b1, cnt_en = 1'b0, chain_en = 1'b0;
  logic [15:0] din = '0;
  logic [15:0] q;
  logic carry_out;

  int total = 0, bad = 0;
  logic [15:0] exp_q = '0;
  bit finished = 0;

  cascade_counter dut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] next_q(logic [15:0] cur, logic c, logic l,
                                         logic [15:0] d, logic pe, logic te);
    if (!c) return 16'h0000;
    if (!l) return d;
    if (pe && te) return cur + 16'h0001;
    return cur;
  endfunction

  function automatic string tag_of(logic c, logic l, logic pe, logic te, logic [15:0] cur);
    if (!c) return "R1";
    if (!l) return "R2";
    if (!te) return "R4";
    if (!pe) return "R5";
    if (cur == 16'hFFFF) return "R7";
    if (cur[3:0] == 4'hF) return "R8";
    return "R3";
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(logic c, logic l, logic [15:0] d, logic pe, logic te);
    string t;
    logic  ec;
    clr_n = c; ld_n = l; din = d; cnt_en = pe; chain_en = te;
    #1;
    ec = te && (exp_q == 16'hFFFF);
    check(te ? "R6" : "R4", {15'd0, carry_out}, {15'd0, ec});
    t = tag_of(c, l, pe, te, exp_q);
    @(posedge clk);
    exp_q = next_q(exp_q, c, l, d, pe, te);
    @(negedge clk);
    check(t, q, exp_q);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(0, 0, 16'h1234, 1, 1);
    check("R1", q, 16'h0000);
    step(1, 0, 16'h00FF, 0, 0);
    step(1, 1, 0, 1, 1);
    check("R8", q, 16'h0100);
    step(1, 0, 16'h0FFF, 1, 1);
    step(1, 1, 0, 1, 1);
    check("R8", q, 16'h1000);
    step(1, 0, 16'hFFFF, 1, 0);
    step(1, 1, 0, 1, 0);
    check("R4", {15'd0, carry_out}, 16'd0);
    step(1, 1, 0, 0, 1);
    check("R6", {15'd0, carry_out}, 16'd1);
    check("R5", q, 16'hFFFF);
    step(1, 1, 0, 1, 1);
    check("R7", q, 16'h0000);
    step(1, 0, 16'hABCD, 0, 1);
    check("R2", q, 16'hABCD);
    step(0, 1, 16'h5555, 0, 0);
    check("R1", q, 16'h0000);
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      logic c, l, pe, te;
      c  = ($urandom % 40) != 0;
      l  = ($urandom % 12) != 0;
      pe = ($urandom % 6) != 0;
      te = ($urandom % 6) != 0;
      d  = ($urandom % 2) ? (16'hFFFF - 16'($urandom % 4)) : 16'($urandom);
      if ($urandom % 3 == 0) d[7:0] = 8'hFD;
      step(c, l, d, pe, te);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule